// File: doc/BRIEF.md
# Single-Word Peripheral-to-Memory Copy Engine

This block copies one word from a peripheral register into data memory without running any processor code. Before use, the processor programs a source address, a destination address and an enable bit. When the peripheral raises its service request, the engine asks the processor for the system bus. The processor finishes its current instruction before it grants the bus.

Once it holds the grant, the engine acknowledges the peripheral and reads the source word. It then writes that word to the destination address. Finally it drops its bus request and its peripheral acknowledge in the same cycle, and raises a done flag.

Two four-phase handshakes are interlocked around every copy. One runs with the peripheral (service request and acknowledge) and one runs with the processor (bus request and grant). The engine does not start another copy until the grant and the peripheral request are both low again.

The bus master port is a simple synchronous one. Read data returns on `bus_rdata` in the cycle after the read strobe.

Top module: `dma_copy_ctrl`

## Requirements
- R1: After reset, `bus_req`, `periph_ack`, `bus_re`, `bus_we` and `xfer_done` are low, and `bus_addr` and `bus_wdata` are zero.
- R2: With enable set, grant low and the peripheral request high at a clock edge, `bus_req` is high from the next cycle, and `periph_ack` stays low until the grant arrives.
- R3: While the enable bit is clear, a peripheral request is ignored and `bus_req` stays low.
- R4: The engine waits any number of cycles for the grant. `bus_re` and `bus_we` are asserted only while `bus_gnt` is high, and `bus_addr` and `bus_wdata` are zero whenever neither strobe is asserted.
- R5: In the cycle after the grant is first seen, `periph_ack` rises together with a one-cycle `bus_re` whose `bus_addr` is the source address.
- R6: The word returned on `bus_rdata` in the cycle after the read strobe is written, two cycles after that strobe, with a one-cycle `bus_we`, with `bus_addr` equal to the destination address and `bus_wdata` equal to the word.
- R7: In the cycle after the write, `bus_req` and `periph_ack` fall in the same cycle.
- R8: After a release, no new `bus_req` is raised until a clock edge at which `bus_gnt` and `periph_req` are both low has passed, even if the peripheral keeps its request high.
- R9: `xfer_done` goes high in the cycle after the write and stays high. A write to the control register (select 2) with bit 1 set clears it. If a clear and a completion happen at the same edge, the completion wins.
- R10: The configuration writes use `cfg_sel`: 0 loads the source address, 1 loads the destination address, and 2 loads the control register, whose bit 0 is the enable. Each copy uses the register values current at its read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 control |
| cfg_wdata | input | AW | Configuration write data |
| periph_req | input | 1 | Peripheral service request |
| periph_ack | output | 1 | Acknowledge to the peripheral |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| bus_addr | output | AW | Bus address |
| bus_re | output | 1 | Bus read strobe |
| bus_we | output | 1 | Bus write strobe |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, valid one cycle after `bus_re` |
| xfer_done | output | 1 | Sticky copy-complete flag |

## Verification
The bench first runs a copy with an immediate grant, then one with a grant delayed by several cycles. A longer wait that stretches only the request phase, and a read and write that keep their spacing, separate a correct design from one that moves on without the grant. A peripheral that holds its request well past the release, and a processor that holds the grant after the release, show whether the engine waits for both lines before restarting. With the enable bit clear, a request that raises no bus request shows the gating. Back-to-back copies to new addresses, with done cleared between them, show that fresh register values are used and that the flag is sticky.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_GNT = 3'd1,
        ST_READ     = 3'd2,
        ST_CAPT     = 3'd3,
        ST_WRITE    = 3'd4,
        ST_RELEASE  = 3'd5
    } xfer_state_e;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_copy_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          copy_done,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          enable,
    output logic          done
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic          en;
        logic          done;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            case (cfg_sel)
                SEL_SRC:  cfg_d.src = cfg_wdata;
                SEL_DST:  cfg_d.dst = cfg_wdata;
                SEL_CTRL: begin
                    cfg_d.en = cfg_wdata[CTRL_EN_BIT];
                    if (cfg_wdata[CTRL_CLR_BIT]) cfg_d.done = 1'b0;
                end
                default: ;
            endcase
        end
        if (copy_done) cfg_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign src_addr = cfg_q.src;
    assign dst_addr = cfg_q.dst;
    assign enable   = cfg_q.en;
    assign done     = cfg_q.done;

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_copy_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        periph_req,
    input  logic        bus_gnt,
    output xfer_state_e state,
    output logic        bus_req,
    output logic        periph_ack,
    output logic        copy_done
);

    typedef struct packed {
        xfer_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            ST_IDLE:     if (enable && periph_req && !bus_gnt) fsm_d.st = ST_WAIT_GNT;
            ST_WAIT_GNT: if (bus_gnt) fsm_d.st = ST_READ;
            ST_READ:     fsm_d.st = ST_CAPT;
            ST_CAPT:     fsm_d.st = ST_WRITE;
            ST_WRITE:    fsm_d.st = ST_RELEASE;
            ST_RELEASE:  if (!bus_gnt && !periph_req) fsm_d.st = ST_IDLE;
            default:     fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= '{st: ST_IDLE};
        else        fsm_q <= fsm_d;
    end

    assign state      = fsm_q.st;
    assign bus_req    = (fsm_q.st == ST_WAIT_GNT) || (fsm_q.st == ST_READ) ||
                        (fsm_q.st == ST_CAPT)     || (fsm_q.st == ST_WRITE);
    assign periph_ack = (fsm_q.st == ST_READ) || (fsm_q.st == ST_CAPT) ||
                        (fsm_q.st == ST_WRITE);
    assign copy_done  = (fsm_q.st == ST_WRITE);

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
    import dma_copy_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_state_e   state,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_re,
    output logic          bus_we,
    output logic [DW-1:0] bus_wdata
);

    typedef struct packed {
        logic [DW-1:0] word;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (state == ST_CAPT) dp_d.word = bus_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    always_comb begin
        bus_re    = (state == ST_READ);
        bus_we    = (state == ST_WRITE);
        bus_addr  = '0;
        bus_wdata = '0;
        if (bus_re) bus_addr = src_addr;
        if (bus_we) begin
            bus_addr  = dst_addr;
            bus_wdata = dp_q.word;
        end
    end

endmodule

// File: rtl/dma_copy_ctrl.sv
module dma_copy_ctrl
    import dma_copy_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          periph_req,
    output logic          periph_ack,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] bus_addr,
    output logic          bus_re,
    output logic          bus_we,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          xfer_done
);

    logic [AW-1:0] src_addr;
    logic [AW-1:0] dst_addr;
    logic          enable;
    logic          copy_done;
    xfer_state_e   state;

    dma_cfg_regs #(.AW(AW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .copy_done (copy_done),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .enable    (enable),
        .done      (xfer_done)
    );

    dma_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .periph_req (periph_req),
        .bus_gnt    (bus_gnt),
        .state      (state),
        .bus_req    (bus_req),
        .periph_ack (periph_ack),
        .copy_done  (copy_done)
    );

    dma_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_re    (bus_re),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata)
    );

endmodule

// File: rtl/dma_copy_ctrl_chk.sv
module dma_copy_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic periph_req,
    input logic periph_ack,
    input logic bus_req,
    input logic bus_gnt,
    input logic bus_re,
    input logic bus_we,
    input logic xfer_done
);

    AST_ACK_INSIDE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> bus_req); // R7

    AST_STROBE_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re || bus_we) |-> bus_gnt); // R4

    AST_DROP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> $fell(periph_ack)); // R7

    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> $past(bus_re, 2)); // R6

    AST_ACK_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_ack) |-> (bus_re && $past(bus_gnt))); // R5

    AST_REQ_FROM_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> ($past(periph_req) && !$past(bus_gnt))); // R2

    AST_NO_QUICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |=> !bus_req); // R8

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> $past(bus_we)); // R9

endmodule

bind dma_copy_ctrl dma_copy_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_req (periph_req),
    .periph_ack (periph_ack),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_re     (bus_re),
    .bus_we     (bus_we),
    .xfer_done  (xfer_done)
);

// File: tb/dma_copy_ctrl_tb.sv
`timescale 1ns/1ps
module dma_copy_ctrl_tb;

    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          periph_req = 1'b0;
    logic          periph_ack;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          bus_re;
    logic          bus_we;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          xfer_done;

    int n_tests = 0;
    int n_fail  = 0;
    int gnt_delay = 0;
    int gnt_cnt   = 0;
    int gnt_hold  = 0;
    int hold_cnt  = 0;
    int cycles    = 0;
    bit finished  = 1'b0;

    logic [DW-1:0] mem [logic [AW-1:0]];

    always #4 clk = ~clk;

    dma_copy_ctrl #(.AW(AW), .DW(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .periph_req (periph_req),
        .periph_ack (periph_ack),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .bus_addr   (bus_addr),
        .bus_re     (bus_re),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .xfer_done  (xfer_done)
    );

    // Memory on the bus: one-cycle read latency.
    always @(posedge clk) begin
        if (bus_re) bus_rdata <= mem.exists(bus_addr) ? mem[bus_addr] : '0;
        if (bus_we) mem[bus_addr] = bus_wdata;
    end

    // Processor: grant after gnt_delay cycles, release gnt_hold cycles after request drops.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_gnt <= 1'b0; gnt_cnt <= 0; hold_cnt <= 0;
        end else if (bus_req && !bus_gnt) begin
            if (gnt_cnt >= gnt_delay) begin bus_gnt <= 1'b1; gnt_cnt <= 0; end
            else gnt_cnt <= gnt_cnt + 1;
        end else if (!bus_req && bus_gnt) begin
            if (hold_cnt >= gnt_hold) begin bus_gnt <= 1'b0; hold_cnt <= 0; end
            else hold_cnt <= hold_cnt + 1;
        end
    end

    // Behavioural reference: phase 0 idle, 1 awaiting grant, 2 read, 3 data back, 4 write, 5 release.
    int            m_phase = 0;
    logic [AW-1:0] m_src = '0, m_dst = '0;
    logic          m_en = 1'b0, m_done = 1'b0;
    logic [DW-1:0] m_word = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase <= 0; m_src <= '0; m_dst <= '0; m_en <= 1'b0; m_done <= 1'b0; m_word <= '0;
        end else begin
            if (m_phase == 0 && m_en && periph_req && !bus_gnt) m_phase <= 1;
            else if (m_phase == 1 && bus_gnt) m_phase <= 2;
            else if (m_phase == 2) m_phase <= 3;
            else if (m_phase == 3) begin
                m_phase <= 4;
                m_word  <= mem.exists(m_src) ? mem[m_src] : '0;
            end
            else if (m_phase == 4) m_phase <= 5;
            else if (m_phase == 5 && !bus_gnt && !periph_req) m_phase <= 0;
            if (cfg_wr && cfg_sel == 2'd0) m_src <= cfg_wdata;
            if (cfg_wr && cfg_sel == 2'd1) m_dst <= cfg_wdata;
            if (m_phase == 4) m_done <= 1'b1;
            else if (cfg_wr && cfg_sel == 2'd2 && cfg_wdata[1]) m_done <= 1'b0;
            if (cfg_wr && cfg_sel == 2'd2) m_en <= cfg_wdata[0];
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Cycle-by-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2", "bus_req",    {31'd0, bus_req},    {31'd0, (m_phase >= 1 && m_phase <= 4)});
            check("R5", "periph_ack", {31'd0, periph_ack}, {31'd0, (m_phase >= 2 && m_phase <= 4)});
            check("R4", "bus_re",     {31'd0, bus_re},     {31'd0, (m_phase == 2)});
            check("R6", "bus_we",     {31'd0, bus_we},     {31'd0, (m_phase == 4)});
            check("R10", "bus_addr",  {16'd0, bus_addr},
                  {16'd0, (m_phase == 2) ? m_src : (m_phase == 4) ? m_dst : 16'd0});
            check("R6", "bus_wdata",  {16'd0, bus_wdata},  {16'd0, (m_phase == 4) ? m_word : 16'd0});
            check("R9", "xfer_done",  {31'd0, xfer_done},  {31'd0, m_done});
        end
    end

    always @(posedge clk) cycles <= cycles + 1;

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic copy_word(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                             input logic [DW-1:0] val, input int gdly, input int ghold, input int rhold);
        mem[src] = val;
        gnt_delay = gdly;
        gnt_hold  = ghold;
        cfg_write(2'd0, src);
        cfg_write(2'd1, dst);
        @(negedge clk);
        periph_req = 1'b1;
        while (!periph_ack) @(negedge clk);
        while (periph_ack) @(negedge clk);
        repeat (rhold) begin
            check("R8", "no restart while request held", {31'd0, bus_req}, 32'd0);
            @(negedge clk);
        end
        periph_req = 1'b0;
        repeat (4) @(negedge clk);
        check("R6", "destination word", {16'd0, mem.exists(dst) ? mem[dst] : 16'd0}, {16'd0, val});
        check("R9", "done after copy", {31'd0, xfer_done}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "bus_req at reset",    {31'd0, bus_req},    32'd0);
        check("R1", "periph_ack at reset", {31'd0, periph_ack}, 32'd0);
        check("R1", "strobes at reset",    {30'd0, bus_re, bus_we}, 32'd0);
        check("R1", "addr at reset",       {16'd0, bus_addr},   32'd0);
        check("R1", "wdata at reset",      {16'd0, bus_wdata},  32'd0);
        check("R1", "done at reset",       {31'd0, xfer_done},  32'd0);
        rst_n = 1'b1;

        // R3: request with enable clear is ignored
        @(negedge clk);
        periph_req = 1'b1;
        repeat (10) begin
            @(negedge clk);
            check("R3", "bus_req while disabled", {31'd0, bus_req}, 32'd0);
        end
        periph_req = 1'b0;
        @(negedge clk);

        cfg_write(2'd2, 16'h0001);
        // R5 R6: immediate grant
        copy_word(16'h8000, 16'h0001, 16'h1234, 0, 0, 0);
        // R9: clear done
        cfg_write(2'd2, 16'h0003);
        @(negedge clk);
        check("R9", "done cleared", {31'd0, xfer_done}, 32'd0);
        // R4 R8 R10: late grant, held grant and held request, new addresses
        copy_word(16'h8002, 16'h0010, 16'hBEEF, 7, 3, 6);
        // R10: back-to-back with different addresses, done stays set
        copy_word(16'h8004, 16'h0020, 16'h5A5A, 2, 0, 1);
        check("R10", "first destination kept", {16'd0, mem[16'h0001]}, 32'h1234);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule